// File: doc/BRIEF.md
# Odd-Parity SECDED Codec (8-bit data, 13-bit codeword)

This block protects a data byte on its way through a noisy path. The encode side takes a byte and produces a 13-bit codeword. The word carries four Hamming check bits and one whole-word parity bit, all with odd parity. The decode side takes a received 13-bit word and returns the byte. It repairs any single flipped bit, and it flags words that cannot be trusted: those with two flipped bits, and those whose check pattern points outside the word.

Each path has one register stage. A word presented with its valid input high appears on the matching outputs one clock later, together with a valid output. When the valid input is low, the registered results keep their last values. The data width is a parameter. The number of check bits and the codeword width follow from it.

Top module: `secded_codec`

## Requirements
- R1: Codeword bit i is position i. Check bits sit at positions 1, 2, 4 and 8, and whole-word parity sits at position 0. Data bits fill positions 3, 5, 6, 7, 9, 10, 11 and 12, with data bit 7 at position 3 and descending to data bit 0 at position 12.
- R2: The bits at the positions whose index has bit k set (k = 0..3) include check bit 2^k. Each such group holds an odd number of ones in every encoded word.
- R3: Every encoded word holds an odd number of ones over all 13 positions.
- R4: Encoding data 8'h6B gives 13'b1101001100101 on `enc_code_o`, one clock after the input.
- R5: Decoding a valid codeword returns its data with both flags low and a syndrome of 0.
- R6: The syndrome has bit k set when group k holds an even count. When overall parity is even and the syndrome is 1 to 12, the bit at that position is flipped back and the single flag is raised. For example, received 13'b1011011010110 decodes to 8'h1D with syndrome 6.
- R7: When overall parity is even and the syndrome is 0, the error is taken to be in position 0. The data passes unchanged and the single flag is raised.
- R8: When overall parity is odd and the syndrome is non-zero, the double flag is raised, the single flag stays low, and the syndrome is reported.
- R9: When overall parity is even and the syndrome is 13 to 15, the double flag is raised, the single flag stays low, and no bit is flipped.
- R10: Each valid output equals its valid input one clock earlier. Results change only on a clock with the matching valid input high. Reset clears every output to 0.
- R11: The single flag and the double flag are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid_i | input | 1 | Encode request |
| enc_data_i | input | 8 | Byte to encode |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | 13 | Received codeword, bit i = position i |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | 13 | Encoded word |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 8 | Corrected data |
| dec_single_o | output | 1 | Single error found and corrected |
| dec_double_o | output | 1 | Uncorrectable error found |
| dec_syndrome_o | output | 4 | Failed-check pattern (bit k = group k) |

## Verification
The bench builds the block with the default data width of 8, which gives 4 check bits and a 13-bit word. This small word lets the bench try every one of the 256 bytes, every single-bit flip at all 13 positions, and every pair and every triple of flips for chosen bytes. The triples are what bring syndromes 13 to 15 within reach: four check bits can name positions beyond the end of the word, and only the out-of-range rule covers those words.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Smallest number of check bits r with 2**r >= data + r + 1.
    function automatic int chk_bits(input int dw);
        int res;
        res = 0;
        for (int r = 1; r < 16; r++) begin
            if (res == 0 && (1 << r) >= dw + r + 1) res = r;
        end
        return res;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Position of the j-th data slot, counting upward from position 3.
    function automatic int data_pos(input int j);
        int seen;
        int res;
        seen = 0;
        res  = 0;
        for (int p = 1; p < 64; p++) begin
            if (!is_pow2(p)) begin
                if (seen == j && res == 0) res = p;
                seen++;
            end
        end
        return res;
    endfunction

    // Positions (>=1) whose index carries bit k.
    function automatic logic [63:0] grp_mask(input int k, input int cw);
        logic [63:0] m;
        m = '0;
        for (int p = 1; p < 64; p++) begin
            if (p < cw && ((p >> k) & 1) == 1) m[p] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CW_W   = 13
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   code_o
);

    logic [CW_W-1:0]  body;   // data in place, check slots zero
    logic [CW_W-1:0]  filled; // data and check bits, slot 0 zero
    logic [CHK_W-1:0] chk;

    for (genvar p = 0; p < CW_W; p++) begin : g_clear
        if (p == 0 || is_pow2(p)) begin : g_zero
            assign body[p] = 1'b0;
        end
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_place
        assign body[data_pos(j)] = data_i[DATA_W-1-j];
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [CW_W-1:0] MASK = CW_W'(grp_mask(k, CW_W));
        assign chk[k] = ~^(body & MASK);
    end

    for (genvar p = 0; p < CW_W; p++) begin : g_fill
        if (p == 0) begin : g_p0
            assign filled[p] = 1'b0;
        end else if (is_pow2(p)) begin : g_pk
            assign filled[p] = chk[$clog2(p)];
        end else begin : g_pd
            assign filled[p] = body[p];
        end
    end

    assign code_o = {filled[CW_W-1:1], ~^filled};

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CW_W   = 13
) (
    input  logic [CW_W-1:0]   code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o,
    output logic [CHK_W-1:0]  syn_o
);

    localparam logic [CHK_W-1:0] LAST_POS = CHK_W'(CW_W - 1);

    logic [CHK_W-1:0] syn;
    logic             par_bad;
    logic             out_of_range;

    for (genvar k = 0; k < CHK_W; k++) begin : g_syn
        localparam logic [CW_W-1:0] MASK = CW_W'(grp_mask(k, CW_W));
        assign syn[k] = ~^(code_i & MASK);
    end

    assign par_bad      = ~^code_i;
    assign out_of_range = syn > LAST_POS;

    for (genvar j = 0; j < DATA_W; j++) begin : g_take
        localparam int POS = data_pos(j);
        assign data_o[DATA_W-1-j] = code_i[POS] ^ (par_bad && syn == CHK_W'(POS));
    end

    assign single_o = par_bad && !out_of_range;
    assign double_o = (!par_bad && syn != '0) || (par_bad && out_of_range);
    assign syn_o    = syn;

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    input  logic              dec_valid_i,
    input  logic [CW_W-1:0]   dec_code_i,
    output logic              enc_valid_o,
    output logic [CW_W-1:0]   enc_code_o,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_single_o,
    output logic              dec_double_o,
    output logic [CHK_W-1:0]  dec_syndrome_o
);

    typedef struct packed {
        logic              enc_v;
        logic [CW_W-1:0]   enc_code;
        logic              dec_v;
        logic [DATA_W-1:0] dec_data;
        logic              dec_single;
        logic              dec_double;
        logic [CHK_W-1:0]  dec_syn;
    } state_t;

    state_t st_d, st_q;

    logic [CW_W-1:0]   enc_word;
    logic [DATA_W-1:0] dec_word;
    logic              dec_sgl;
    logic              dec_dbl;
    logic [CHK_W-1:0]  dec_syn;

    secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) enc_i (
        .data_i (enc_data_i),
        .code_o (enc_word)
    );

    secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) dec_i (
        .code_i   (dec_code_i),
        .data_o   (dec_word),
        .single_o (dec_sgl),
        .double_o (dec_dbl),
        .syn_o    (dec_syn)
    );

    always_comb begin
        st_d       = st_q;
        st_d.enc_v = enc_valid_i;
        st_d.dec_v = dec_valid_i;
        if (enc_valid_i) begin
            st_d.enc_code = enc_word;
        end
        if (dec_valid_i) begin
            st_d.dec_data   = dec_word;
            st_d.dec_single = dec_sgl;
            st_d.dec_double = dec_dbl;
            st_d.dec_syn    = dec_syn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enc_valid_o    = st_q.enc_v;
    assign enc_code_o     = st_q.enc_code;
    assign dec_valid_o    = st_q.dec_v;
    assign dec_data_o     = st_q.dec_data;
    assign dec_single_o   = st_q.dec_single;
    assign dec_double_o   = st_q.dec_double;
    assign dec_syndrome_o = st_q.dec_syn;

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
    import secded_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic [DATA_W-1:0] enc_data_i,
    input logic              dec_valid_i,
    input logic [CW_W-1:0]   dec_code_i,
    input logic              enc_valid_o,
    input logic [CW_W-1:0]   enc_code_o,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_single_o,
    input logic              dec_double_o,
    input logic [CHK_W-1:0]  dec_syndrome_o
);

    a_r10_enc_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i |=> enc_valid_o);

    a_r10_enc_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> !enc_valid_o);

    a_r10_dec_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    a_r10_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid_i |=> $stable(enc_code_o));

    a_r10_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_syndrome_o)));

    a_r3_overall_odd: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> (^enc_code_o));

    for (genvar k = 0; k < CHK_W; k++) begin : g_grp
        localparam logic [CW_W-1:0] MASK = CW_W'(grp_mask(k, CW_W));
        a_r2_group_odd: assert property (@(posedge clk) disable iff (!rst_n)
            enc_valid_o |-> (^(enc_code_o & MASK)));
    end

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_single_o && dec_double_o));

    a_r8_double_has_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
        dec_double_o |-> (dec_syndrome_o != '0));

    // R5: a freshly encoded word fed back decodes clean.
    a_r5_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && enc_valid_o && dec_code_i == enc_code_o) |=>
            (!dec_single_o && !dec_double_o && dec_syndrome_o == '0));

    logic unused_ok;
    assign unused_ok = ^{enc_data_i, dec_valid_o};

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .enc_valid_i    (enc_valid_i),
    .enc_data_i     (enc_data_i),
    .dec_valid_i    (dec_valid_i),
    .dec_code_i     (dec_code_i),
    .enc_valid_o    (enc_valid_o),
    .enc_code_o     (enc_code_o),
    .dec_valid_o    (dec_valid_o),
    .dec_data_o     (dec_data_o),
    .dec_single_o   (dec_single_o),
    .dec_double_o   (dec_double_o),
    .dec_syndrome_o (dec_syndrome_o)
);

// File: tb/secded_codec_tb.sv
module secded_codec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid_i = 1'b0;
    logic [7:0]  enc_data_i = '0;
    logic        dec_valid_i = 1'b0;
    logic [12:0] dec_code_i = '0;
    logic        enc_valid_o;
    logic [12:0] enc_code_o;
    logic        dec_valid_o;
    logic [7:0]  dec_data_o;
    logic        dec_single_o;
    logic        dec_double_o;
    logic [3:0]  dec_syndrome_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    secded_codec dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .enc_valid_i    (enc_valid_i),
        .enc_data_i     (enc_data_i),
        .dec_valid_i    (dec_valid_i),
        .dec_code_i     (dec_code_i),
        .enc_valid_o    (enc_valid_o),
        .enc_code_o     (enc_code_o),
        .dec_valid_o    (dec_valid_o),
        .dec_data_o     (dec_data_o),
        .dec_single_o   (dec_single_o),
        .dec_double_o   (dec_double_o),
        .dec_syndrome_o (dec_syndrome_o)
    );

    // Reference model: positions held as integers, counted behaviourally.
    function automatic bit m_pow2(input int p);
        return (p == 1) || (p == 2) || (p == 4) || (p == 8);
    endfunction

    function automatic logic [12:0] m_encode(input logic [7:0] d);
        logic [12:0] w;
        int di;
        w  = '0;
        di = 7;
        for (int p = 1; p <= 12; p++) begin
            if (!m_pow2(p)) begin
                w[p] = d[di];
                di--;
            end
        end
        for (int k = 0; k < 4; k++) begin
            int c;
            c = 0;
            for (int p = 1; p <= 12; p++) begin
                if (((p >> k) & 1) == 1 && p != (1 << k)) c += int'(w[p]);
            end
            w[1 << k] = (c % 2 == 0);
        end
        w[0] = ($countones(w) % 2 == 0);
        return w;
    endfunction

    function automatic void m_decode(input logic [12:0] w, output logic [7:0] d,
                                     output logic s, output logic db, output logic [3:0] sy);
        int syn;
        int di;
        bit bad;
        logic [12:0] f;
        syn = 0;
        for (int k = 0; k < 4; k++) begin
            int c;
            c = 0;
            for (int p = 1; p <= 12; p++) begin
                if (((p >> k) & 1) == 1) c += int'(w[p]);
            end
            if (c % 2 == 0) syn += (1 << k);
        end
        bad = ($countones(w) % 2 == 0);
        f = w;
        if (bad && syn >= 1 && syn <= 12) f[syn] = ~f[syn];
        di = 7;
        d  = '0;
        for (int p = 1; p <= 12; p++) begin
            if (!m_pow2(p)) begin
                d[di] = f[p];
                di--;
            end
        end
        s  = bad && syn <= 12;
        db = (!bad && syn != 0) || (bad && syn > 12);
        sy = 4'(syn);
    endfunction

    logic        x_ev = 1'b0;
    logic [12:0] x_code = '0;
    logic        x_dv = 1'b0;
    logic [7:0]  x_data = '0;
    logic        x_s = 1'b0;
    logic        x_d = 1'b0;
    logic [3:0]  x_syn = '0;
    string       cur_tag = "R10 reset";

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_tag, "enc_valid", 32'(enc_valid_o), 32'(x_ev));
        chk(cur_tag, "enc_code", 32'(enc_code_o), 32'(x_code));
        chk(cur_tag, "dec_valid", 32'(dec_valid_o), 32'(x_dv));
        chk(cur_tag, "dec_data", 32'(dec_data_o), 32'(x_data));
        chk(cur_tag, "single", 32'(dec_single_o), 32'(x_s));
        chk(cur_tag, "double", 32'(dec_double_o), 32'(x_d));
        chk(cur_tag, "syndrome", 32'(dec_syndrome_o), 32'(x_syn));
        chk("R11", "flags both high", 32'(dec_single_o & dec_double_o), 32'd0);
    endtask

    // Compare outputs from the previous step, then drive the next one.
    task automatic step(input logic ev, input logic [7:0] ed, input logic dv,
                        input logic [12:0] dw, input string tag);
        @(negedge clk);
        compare_all();
        enc_valid_i = ev;
        enc_data_i  = ed;
        dec_valid_i = dv;
        dec_code_i  = dw;
        x_ev = ev;
        if (ev) x_code = m_encode(ed);
        x_dv = dv;
        if (dv) m_decode(dw, x_data, x_s, x_d, x_syn);
        cur_tag = tag;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [12:0] w;
        repeat (3) @(negedge clk);
        // R10: outputs cleared in reset
        compare_all();
        rst_n = 1'b1;

        // R1 / R4: model sanity against the known vector
        chk("R1", "model encode 6B", 32'(m_encode(8'h6B)), 32'(13'b1101001100101));

        // R4: encode 8'h6B, then idle
        step(1'b1, 8'h6B, 1'b0, '0, "R4");
        step(1'b0, 8'h00, 1'b0, '0, "R10");
        chk("R4", "enc_code 6B", 32'(enc_code_o), 32'(13'b1101001100101));

        // R6: known received word with position 6 flipped
        step(1'b0, 8'h00, 1'b1, 13'b1011011010110, "R6");
        step(1'b0, 8'h00, 1'b0, '0, "R10");
        chk("R6", "known data", 32'(dec_data_o), 32'h1D);
        chk("R6", "known syndrome", 32'(dec_syndrome_o), 32'd6);
        chk("R6", "known single", 32'(dec_single_o), 32'd1);

        // R1 R2 R3 R5: every byte encoded, and a clean word decoded alongside
        for (int d = 0; d < 256; d++) begin
            step(1'b1, 8'(d), 1'b1, m_encode(8'(d ^ 8'h5A)), "R2/R3/R5");
        end

        // R6 R7: every single flip for several bytes
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h6B : 8'hA5;
            for (int p = 0; p < 13; p++) begin
                w = m_encode(b);
                w[p] = ~w[p];
                step(1'b0, 8'h00, 1'b1, w, (p == 0) ? "R7" : "R6");
            end
        end
        w = m_encode(8'h3C);
        w[0] = ~w[0];
        step(1'b0, 8'h00, 1'b1, w, "R7");
        step(1'b0, 8'h00, 1'b0, '0, "R10");
        chk("R7", "p0 data", 32'(dec_data_o), 32'h3C);
        chk("R7", "p0 single", 32'(dec_single_o), 32'd1);

        // R8: every pair of flips
        for (int i = 0; i < 2; i++) begin
            for (int p = 0; p < 13; p++) begin
                for (int q = p + 1; q < 13; q++) begin
                    w = m_encode(i == 0 ? 8'h96 : 8'h01);
                    w[p] = ~w[p];
                    w[q] = ~w[q];
                    step(1'b0, 8'h00, 1'b1, w, "R8");
                end
            end
        end

        // R9: triples naming positions 13, 14 and 15, then all triples
        w = m_encode(8'h77); w[1] = ~w[1]; w[4] = ~w[4]; w[8] = ~w[8];
        step(1'b0, 8'h00, 1'b1, w, "R9");
        step(1'b0, 8'h00, 1'b0, '0, "R10");
        chk("R9", "syn 13 double", 32'(dec_double_o), 32'd1);
        chk("R9", "syn 13 value", 32'(dec_syndrome_o), 32'd13);
        w = m_encode(8'h77); w[2] = ~w[2]; w[4] = ~w[4]; w[8] = ~w[8];
        step(1'b0, 8'h00, 1'b1, w, "R9");
        w = m_encode(8'h77); w[3] = ~w[3]; w[4] = ~w[4]; w[8] = ~w[8];
        step(1'b0, 8'h00, 1'b1, w, "R9");
        for (int p = 0; p < 13; p++) begin
            for (int q = p + 1; q < 13; q++) begin
                for (int r = q + 1; r < 13; r++) begin
                    w = m_encode(8'hC3);
                    w[p] = ~w[p]; w[q] = ~w[q]; w[r] = ~w[r];
                    step(1'b0, 8'h00, 1'b1, w, "R9");
                end
            end
        end

        // R10: inputs change with valid low; results must hold
        step(1'b1, 8'h12, 1'b1, m_encode(8'h34), "R10");
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 8'(i * 37), 1'b0, 13'(i * 911), "R10");
        end
        step(1'b0, 8'h00, 1'b0, '0, "R10");
        chk("R10", "held enc", 32'(enc_code_o), 32'(m_encode(8'h12)));
        chk("R10", "held dec", 32'(dec_data_o), 32'h34);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule